// File: doc/BRIEF.md
# Dual-Compare PWM Generator

This block produces a square wave whose period and duty ratio are both set by two compare values checked against one up counter. The counter advances on each prescaler tick while the block is running. When the count reaches the duty value, the output moves to its active level and a duty interrupt pulse is raised. When the count reaches the period value, the output returns to its idle level, a period interrupt pulse is raised and the counter restarts from zero. One period therefore lasts the period value plus one tick.

A 2-bit output-control code selects the polarity. Code 01 gives an active-high pulse. Code 10 gives an active-low pulse. Codes 00 and 11 freeze the output at whatever level it holds. Compare values go into shadow registers. While the block is stopped the shadows follow the inputs. While it is running they reload only at a period boundary, so a value written in mid-period never cuts a pulse short. Dropping the run input clears the counter and parks the output at its idle level.

Top module: `pwm_dual_compare`

## Requirements
- R1: While synchronous reset is high, at the next clock edge pwm_out, irq_duty and irq_period all become 0 and the counter becomes 0.
- R2: The counter advances by one only on a clock edge where run and tick are both 1. With tick low, no interrupt fires and the output does not change.
- R3: On a counting edge where the counter equals the active duty value and that value is below the active period value, irq_duty is 1 for exactly the next cycle and the output takes its active level.
- R4: On a counting edge where the counter equals the active period value, irq_period is 1 for the next cycle, the counter returns to 0 and the output takes its idle level. A period spans period value + 1 ticks.
- R5: Control code 2'b01 makes the active level 1 and the idle level 0. Control code 2'b10 makes the active level 0 and the idle level 1.
- R6: Control codes 2'b00 and 2'b11 hold pwm_out at its present level, whether running or stopped. Interrupts still fire.
- R7: If the active duty value is greater than or equal to the active period value, irq_duty never fires, the output stays idle, and irq_period still fires once per period. The two interrupts are never high together.
- R8: The active compare values load from duty_val and period_val on every edge while run is 0, and on every period-match edge while running. A mid-period write takes effect from the next period.
- R9: While run is 0, the counter is held at 0 and, under code 01 or 10, the output becomes the idle level at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaler count enable, one cycle per tick |
| run | input | 1 | Count enable. Low stops and clears the counter |
| duty_val | input | W | Compare value for the duty edge |
| period_val | input | W | Compare value for the period edge |
| oc_mode | input | 2 | Output control: 01 active-high, 10 active-low, 00/11 freeze |
| pwm_out | output | 1 | Registered pulse output |
| irq_duty | output | 1 | One-cycle pulse on a duty match |
| irq_period | output | 1 | One-cycle pulse on a period match |

## Verification
The bench builds the block with its default width of 8 bits. This puts the full compare range in reach. The table covers a period value of 255 with duty values 0 and 254, the degenerate period of 0, and duty values equal to and above the period. With the narrow default, a complete 256-tick period runs three times within a few hundred cycles. Directed runs cover mid-period compare writes, gapped ticks and switching between frozen and driving control codes.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    OC_HOLD_A = 2'b00,
    OC_HIGH   = 2'b01,
    OC_LOW    = 2'b10,
    OC_HOLD_B = 2'b11
  } oc_mode_e;

  localparam int N_CMP = 2;
  localparam int CMP_DUTY = 0;
  localparam int CMP_PER = 1;

  function automatic logic oc_drives(input logic [1:0] m);
    return (m == OC_HIGH) || (m == OC_LOW);
  endfunction

  function automatic logic oc_idle(input logic [1:0] m);
    return (m == OC_LOW);
  endfunction
endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] duty_in,
  input  logic [W-1:0] per_in,
  output logic [W-1:0] duty_q,
  output logic [W-1:0] per_q
);
  import pwm_pkg::*;

  logic [W-1:0] src [N_CMP];
  logic [W-1:0] shd [N_CMP];

  assign src[CMP_DUTY] = duty_in;
  assign src[CMP_PER]  = per_in;

  for (genvar gi = 0; gi < N_CMP; gi++) begin : g_shd
    always_ff @(posedge clk) begin
      if (rst) begin
        shd[gi] <= '0;
      end else if (load) begin
        shd[gi] <= src[gi];
      end
    end
  end

  assign duty_q = shd[CMP_DUTY];
  assign per_q  = shd[CMP_PER];
endmodule

// File: rtl/pwm_match.sv
module pwm_match #(
  parameter int W = 8
) (
  input  logic         step,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] duty,
  input  logic [W-1:0] per,
  output logic         duty_hit,
  output logic         per_hit
);
  logic duty_valid;

  always_comb begin
    duty_valid = (duty < per);
    per_hit    = step && (cnt == per);
    duty_hit   = step && duty_valid && (cnt == duty);
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         step,
  input  logic         wrap,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (wrap) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/pwm_outctl.sv
module pwm_outctl (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] mode,
  input  logic       duty_hit,
  input  logic       per_hit,
  output logic       pwm_q,
  output logic       irq_duty_q,
  output logic       irq_per_q
);
  import pwm_pkg::*;

  logic drives;
  logic idle_lvl;

  always_comb begin
    drives   = oc_drives(mode);
    idle_lvl = oc_idle(mode);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q      <= 1'b0;
      irq_duty_q <= 1'b0;
      irq_per_q  <= 1'b0;
    end else begin
      irq_duty_q <= duty_hit;
      irq_per_q  <= per_hit;
      if (drives) begin
        if (!run || per_hit) begin
          pwm_q <= idle_lvl;
        end else if (duty_hit) begin
          pwm_q <= ~idle_lvl;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_dual_compare.sv
module pwm_dual_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         run,
  input  logic [W-1:0] duty_val,
  input  logic [W-1:0] period_val,
  input  logic [1:0]   oc_mode,
  output logic         pwm_out,
  output logic         irq_duty,
  output logic         irq_period
);
  logic         step;
  logic         duty_hit;
  logic         per_hit;
  logic         shd_load;
  logic [W-1:0] cnt_q;
  logic [W-1:0] duty_act;
  logic [W-1:0] per_act;

  assign step     = run && tick;
  assign shd_load = !run || per_hit;

  pwm_shadow #(.W(W)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .load    (shd_load),
    .duty_in (duty_val),
    .per_in  (period_val),
    .duty_q  (duty_act),
    .per_q   (per_act)
  );

  pwm_match #(.W(W)) u_match (
    .step     (step),
    .cnt      (cnt_q),
    .duty     (duty_act),
    .per      (per_act),
    .duty_hit (duty_hit),
    .per_hit  (per_hit)
  );

  pwm_counter #(.W(W)) u_counter (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .step (step),
    .wrap (per_hit),
    .cnt  (cnt_q)
  );

  pwm_outctl u_outctl (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .mode       (oc_mode),
    .duty_hit   (duty_hit),
    .per_hit    (per_hit),
    .pwm_q      (pwm_out),
    .irq_duty_q (irq_duty),
    .irq_per_q  (irq_period)
  );
endmodule

// File: rtl/pwm_dual_compare_chk.sv
module pwm_dual_compare_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         run,
  input logic [1:0]   oc_mode,
  input logic         pwm_out,
  input logic         irq_duty,
  input logic         irq_period,
  input logic [W-1:0] cnt,
  input logic [W-1:0] per_q
);
  // R7: duty and period interrupts never coincide
  p_irq_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(irq_duty && irq_period));

  // R3: a duty interrupt lasts one cycle
  p_duty_single_r3: assert property (@(posedge clk) disable iff (rst)
    irq_duty |=> !irq_duty);

  // R3 / R5: duty match under active-high code leaves the output high
  p_duty_active_r3: assert property (@(posedge clk) disable iff (rst)
    (irq_duty && $past(oc_mode) == 2'b01) |-> pwm_out);

  // R4 / R5: period match under active-low code leaves the output high (idle)
  p_period_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_period && $past(oc_mode) == 2'b10) |-> pwm_out);

  // R4: counter never runs past the active period value
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= per_q);

  // R2: no tick, no count
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt));

  // R6: frozen codes keep the output steady
  p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    (oc_mode == 2'b00 || oc_mode == 2'b11) |=> $stable(pwm_out));

  // R9: stopping under active-high code parks the output low
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!run && oc_mode == 2'b01) |=> (!pwm_out && cnt == '0));
endmodule

bind pwm_dual_compare pwm_dual_compare_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .run        (run),
  .oc_mode    (oc_mode),
  .pwm_out    (pwm_out),
  .irq_duty   (irq_duty),
  .irq_period (irq_period),
  .cnt        (cnt_q),
  .per_q      (per_act)
);

// File: tb/pwm_dual_compare_bench.sv
module pwm_dual_compare_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 8;
  // {mode, duty, period}
  localparam logic [17:0] VEC [NVEC] = '{
    {2'b01, 8'd3,   8'd9},
    {2'b10, 8'd3,   8'd9},
    {2'b01, 8'd0,   8'd1},
    {2'b10, 8'd0,   8'd255},
    {2'b01, 8'd254, 8'd255},
    {2'b10, 8'd5,   8'd5},
    {2'b01, 8'd7,   8'd2},
    {2'b01, 8'd0,   8'd0}
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         tick;
  logic         run;
  logic [W-1:0] duty_val;
  logic [W-1:0] period_val;
  logic [1:0]   oc_mode;
  logic         pwm_out;
  logic         irq_duty;
  logic         irq_period;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_dual_compare #(.W(W)) u_pwm_dual_compare (
    .clk(clk), .rst(rst), .tick(tick), .run(run),
    .duty_val(duty_val), .period_val(period_val), .oc_mode(oc_mode),
    .pwm_out(pwm_out), .irq_duty(irq_duty), .irq_period(irq_period)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic stop_load(input logic [1:0] m, input int d, input int p);
    run = 1'b0; tick = 1'b0; oc_mode = m;
    duty_val = W'(d); period_val = W'(p);
    edge1(); edge1();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int act_cnt, nd, np, fd, e;
    int pe [4];
    int de [4];
    rst = 1'b1; run = 1'b0; tick = 1'b0;
    duty_val = '0; period_val = '0; oc_mode = 2'b10;
    @(negedge clk);
    edge1(); edge1();
    // R1: reset state
    chk("R1 pwm_out", int'(pwm_out), 0);
    chk("R1 irq_duty", int'(irq_duty), 0);
    chk("R1 irq_period", int'(irq_period), 0);
    rst = 1'b0;

    // Table walk: R3 R4 R5 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] m;
      int d, p, act_lvl;
      m = VEC[v][17:16]; d = int'(VEC[v][15:8]); p = int'(VEC[v][7:0]);
      act_lvl = (m == 2'b01) ? 1 : 0;
      stop_load(m, d, p);
      chk("R9 idle while stopped", int'(pwm_out), 1 - act_lvl);
      run = 1'b1; tick = 1'b1;
      act_cnt = 0; nd = 0; np = 0; fd = -1;
      for (int k = 1; k <= 3 * (p + 1); k++) begin
        edge1();
        if (int'(pwm_out) == act_lvl) act_cnt++;
        if (irq_duty) begin nd++; if (fd < 0) fd = k; end
        if (irq_period) np++;
      end
      chk("R5 active samples", act_cnt, (d < p) ? 3 * (p - d) : 0);
      chk("R3 duty irqs", nd, (d < p) ? 3 : 0);
      chk("R4 period irqs", np, 3);
      chk("R3 first duty edge", fd, (d < p) ? d + 1 : -1);
    end

    // R2: no ticks, then gapped ticks
    stop_load(2'b01, 1, 3);
    run = 1'b1; tick = 1'b0;
    nd = 0; np = 0; act_cnt = 0;
    for (int k = 0; k < 10; k++) begin
      edge1();
      if (irq_duty) nd++;
      if (irq_period) np++;
      if (pwm_out) act_cnt++;
    end
    chk("R2 no irq without tick", nd + np, 0);
    chk("R2 output unchanged without tick", act_cnt, 0);
    nd = 0; np = 0;
    for (int k = 0; k < 8; k++) begin
      tick = 1'b1; edge1();
      if (irq_duty) nd++;
      if (irq_period) np++;
      tick = 1'b0; edge1();
      if (irq_duty) nd++;
      if (irq_period) np++;
    end
    chk("R2 period irqs over 8 ticks", np, 2);
    chk("R2 duty irqs over 8 ticks", nd, 2);

    // R6: freeze codes
    stop_load(2'b01, 3, 9);
    run = 1'b1; tick = 1'b1;
    for (int k = 0; k < 5; k++) edge1();
    chk("R6 active before freeze", int'(pwm_out), 1);
    oc_mode = 2'b00;
    act_cnt = 0; np = 0;
    for (int k = 0; k < 15; k++) begin
      edge1();
      if (!pwm_out) act_cnt++;
      if (irq_period) np++;
    end
    chk("R6 output held under code 00", act_cnt, 0);
    chk("R6 irqs still fire", np, 2);
    run = 1'b0; edge1(); edge1();
    chk("R6 held while stopped under 00", int'(pwm_out), 1);
    oc_mode = 2'b11; edge1();
    chk("R6 held under code 11", int'(pwm_out), 1);
    oc_mode = 2'b01; edge1();
    chk("R9 idle after leaving freeze", int'(pwm_out), 0);

    // R8: mid-period compare write waits for the boundary
    stop_load(2'b01, 3, 9);
    run = 1'b1; tick = 1'b1;
    nd = 0; np = 0;
    for (int i = 0; i < 4; i++) begin pe[i] = -1; de[i] = -1; end
    for (e = 1; e <= 20; e++) begin
      if (e == 3) begin duty_val = 8'd1; period_val = 8'd4; end
      edge1();
      if (irq_period && np < 4) begin pe[np] = e; np++; end
      if (irq_duty && nd < 4) begin de[nd] = e; nd++; end
    end
    chk("R8 first period keeps old value", pe[0], 10);
    chk("R8 second period uses new value", pe[1], 15);
    chk("R8 first duty keeps old value", de[0], 4);
    chk("R8 second duty uses new value", de[1], 12);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule